// File: doc/BRIEF.md
# Porter-Duff Pixel Compositor

This block merges two ARGB pixels, a source and a destination, into one ARGB pixel using the Porter-Duff compositing rules. The two inputs are taken as premultiplied. Each input is multiplied by its own 8-bit weight, and the per-channel sum of the two products is rescaled to 8 bits. The alpha channel goes through the same arithmetic as the colour channels.

A weight is picked from four choices: nothing, full, the other pixel's alpha, or the complement of the other pixel's alpha. A 4-bit operator code picks the pair of weights from a fixed table of twelve operators. A direct-select input lets the caller choose the two weights itself instead. An operator code outside the table is refused: the block flags an error and writes transparent black.

Pixels arrive and leave on valid/ready streams, and one output register sits between them. The usual users are a display overlay path or a blitter that streams one pixel pair per cycle.

Top module: `pd_compositor`

## Requirements
- R1: While reset is active and right after it, outValid is 0 and inReady is 1.
- R2: A pixel pair accepted on a clock edge (inValid and inReady both high) appears on outPix/outErr with outValid high after that edge. While outValid is high and outReady is low, the outputs hold their values and inReady is low. When outReady is high, a new pair is accepted in the same cycle that the old result leaves.
- R3: The weight codes are 0 = zero, 1 = full (255), 2 = other alpha, 3 = 255 minus other alpha. The source weight uses the destination alpha as "other", and the destination weight uses the source alpha.
- R4: Pixels are packed as A[31:24], R[23:16], G[15:8], B[7:0]. For each of the four channels, out = (src·wSrc + dst·wDst + 127) / 255, using integer division.
- R5: The operator codes give these (source weight, destination weight) pairs: 0 Clear (0,0), 1 Src (1,0), 2 Dst (0,1), 3 Over (1,3), 4 DstOver (3,1), 5 In (2,0), 6 DstIn (0,2), 7 Out (3,0), 8 DstOut (0,3), 9 Atop (2,3), 10 DstAtop (3,2), 11 Xor (3,3).
- R6: Src reproduces the source pixel exactly. Dst reproduces the destination pixel exactly. Clear gives 0x00000000.
- R7: With useDirect high, the weights come from directF0 (source) and directF1 (destination). opMode is then ignored, even when it holds an out-of-table code, and outErr stays 0.
- R8: With useDirect low, an operator code of 12 to 15 gives outErr = 1 and outPix = 0x00000000. Any code from 0 to 11 gives outErr = 0.
- R9: A channel result above 255 is clamped to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel pair is present |
| inReady | output | 1 | Block can take a pair this cycle |
| srcPix | input | 32 | Source pixel, ARGB8888 |
| dstPix | input | 32 | Destination pixel, ARGB8888 |
| opMode | input | 4 | Operator code |
| useDirect | input | 1 | Use directF0/directF1 instead of the operator table |
| directF0 | input | 2 | Source weight code in direct mode |
| directF1 | input | 2 | Destination weight code in direct mode |
| outValid | output | 1 | Result is present |
| outReady | input | 1 | Consumer takes the result |
| outPix | output | 32 | Composited pixel, ARGB8888 |
| outErr | output | 1 | Result came from an invalid operator code |

## Verification
A wrong entry in the operator table or a swapped "other alpha" reference shows up as a wrong outPix one cycle after the pair is accepted. Random alphas and colours make such a fault visible on almost every pixel sent with the affected operator. A faulty hold or ready path shows as a changed outPix or a high inReady during the first stalled cycle. A bad saturation or rounding term shows only on chosen values, so directed pixels at the clamp and rounding limits are sent as well.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    FAC_ZERO      = 2'd0,
    FAC_ONE       = 2'd1,
    FAC_OTHER     = 2'd2,
    FAC_INV_OTHER = 2'd3
  } facSel_e;

  localparam int NUM_OPS = 12;

  typedef struct packed {
    logic    load;
    facSel_e selF0;
    facSel_e selF1;
    logic    bad;
  } pdStrobe_t;
endpackage

// File: rtl/pd_ctrl.sv
module pd_ctrl
  import pd_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [MODE_W-1:0] opMode,
  input  logic              useDirect,
  input  logic [1:0]        directF0,
  input  logic [1:0]        directF1,
  output logic              outValid,
  input  logic              outReady,
  output pdStrobe_t         strobe
);
  localparam logic [MODE_W-1:0] OP_LIMIT = MODE_W'(NUM_OPS);

  facSel_e tabF0, tabF1;

  always_comb begin
    tabF0 = FAC_ZERO;
    tabF1 = FAC_ZERO;
    case (opMode)
      MODE_W'(1):  begin tabF0 = FAC_ONE;       tabF1 = FAC_ZERO;      end
      MODE_W'(2):  begin tabF0 = FAC_ZERO;      tabF1 = FAC_ONE;       end
      MODE_W'(3):  begin tabF0 = FAC_ONE;       tabF1 = FAC_INV_OTHER; end
      MODE_W'(4):  begin tabF0 = FAC_INV_OTHER; tabF1 = FAC_ONE;       end
      MODE_W'(5):  begin tabF0 = FAC_OTHER;     tabF1 = FAC_ZERO;      end
      MODE_W'(6):  begin tabF0 = FAC_ZERO;      tabF1 = FAC_OTHER;     end
      MODE_W'(7):  begin tabF0 = FAC_INV_OTHER; tabF1 = FAC_ZERO;      end
      MODE_W'(8):  begin tabF0 = FAC_ZERO;      tabF1 = FAC_INV_OTHER; end
      MODE_W'(9):  begin tabF0 = FAC_OTHER;     tabF1 = FAC_INV_OTHER; end
      MODE_W'(10): begin tabF0 = FAC_INV_OTHER; tabF1 = FAC_OTHER;     end
      MODE_W'(11): begin tabF0 = FAC_INV_OTHER; tabF1 = FAC_INV_OTHER; end
      default:     begin tabF0 = FAC_ZERO;      tabF1 = FAC_ZERO;      end
    endcase
  end

  assign inReady = !outValid || outReady;

  always_comb begin
    strobe.load  = inValid && inReady;
    strobe.bad   = !useDirect && (opMode >= OP_LIMIT);
    strobe.selF0 = useDirect ? facSel_e'(directF0) : tabF0;
    strobe.selF1 = useDirect ? facSel_e'(directF1) : tabF1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 outValid <= 1'b0;
    else if (inValid && inReady) outValid <= 1'b1;
    else if (outReady)         outValid <= 1'b0;
  end

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady); // R2
  AST_ACCEPT_PRESENTS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid); // R2
  AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid); // R2
endmodule

// File: rtl/pd_datapath.sv
module pd_datapath
  import pd_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int NUM_CH = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pdStrobe_t              strobe,
  input  logic [CH_W*NUM_CH-1:0] srcPix,
  input  logic [CH_W*NUM_CH-1:0] dstPix,
  output logic [CH_W*NUM_CH-1:0] outPix,
  output logic                   outErr
);
  localparam int PIX_W = CH_W * NUM_CH;
  localparam int SUM_W = 2 * CH_W + 1;
  localparam logic [CH_W-1:0]  FULL   = {CH_W{1'b1}};
  localparam logic [SUM_W-1:0] FULL_S = SUM_W'(FULL);
  localparam logic [SUM_W-1:0] HALF_S = SUM_W'(FULL >> 1);

  logic [CH_W-1:0]  srcA, dstA, wSrc, wDst;
  logic [PIX_W-1:0] mixPix;

  assign srcA = srcPix[PIX_W-1 -: CH_W];
  assign dstA = dstPix[PIX_W-1 -: CH_W];

  function automatic logic [CH_W-1:0] pickWeight(input facSel_e sel, input logic [CH_W-1:0] otherA);
    case (sel)
      FAC_ZERO:      pickWeight = '0;
      FAC_ONE:       pickWeight = FULL;
      FAC_OTHER:     pickWeight = otherA;
      default:       pickWeight = FULL - otherA;
    endcase
  endfunction

  assign wSrc = pickWeight(strobe.selF0, dstA);
  assign wDst = pickWeight(strobe.selF1, srcA);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    logic [CH_W-1:0]  sVal, dVal;
    logic [SUM_W-1:0] acc, quo;
    assign sVal = srcPix[ch*CH_W +: CH_W];
    assign dVal = dstPix[ch*CH_W +: CH_W];
    assign acc  = SUM_W'(sVal) * SUM_W'(wSrc) + SUM_W'(dVal) * SUM_W'(wDst) + HALF_S;
    assign quo  = acc / FULL_S;
    assign mixPix[ch*CH_W +: CH_W] = (quo > FULL_S) ? FULL : quo[CH_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPix <= '0;
      outErr <= 1'b0;
    end else if (strobe.load) begin
      outPix <= strobe.bad ? '0 : mixPix;
      outErr <= strobe.bad;
    end
  end

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(outPix) && $stable(outErr))); // R2
  AST_ERR_IS_BLACK: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> (outPix == '0)); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.selF0 == FAC_ZERO && strobe.selF1 == FAC_ZERO) |=> (outPix == '0)); // R6
  AST_SRC_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.bad && strobe.selF0 == FAC_ONE && strobe.selF1 == FAC_ZERO)
      |=> (outPix == $past(srcPix))); // R6
endmodule

// File: rtl/pd_compositor.sv
module pd_compositor
  import pd_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int NUM_CH = 4,
  parameter int MODE_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [CH_W*NUM_CH-1:0] srcPix,
  input  logic [CH_W*NUM_CH-1:0] dstPix,
  input  logic [MODE_W-1:0]      opMode,
  input  logic                   useDirect,
  input  logic [1:0]             directF0,
  input  logic [1:0]             directF1,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [CH_W*NUM_CH-1:0] outPix,
  output logic                   outErr
);
  pdStrobe_t strobe;

  pd_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opMode(opMode), .useDirect(useDirect), .directF0(directF0), .directF1(directF1),
    .outValid(outValid), .outReady(outReady), .strobe(strobe)
  );

  pd_datapath #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcPix(srcPix), .dstPix(dstPix),
    .outPix(outPix), .outErr(outErr)
  );
endmodule

// File: tb/pd_compositor_tb.sv
`timescale 1ns/1ps
module pd_compositor_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] srcPix = '0, dstPix = '0;
  logic [3:0]  opMode = '0;
  logic        useDirect = 1'b0;
  logic [1:0]  directF0 = '0, directF1 = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outPix;
  logic        outErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pd_compositor u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .srcPix(srcPix), .dstPix(dstPix), .opMode(opMode), .useDirect(useDirect),
    .directF0(directF0), .directF1(directF1), .outValid(outValid),
    .outReady(outReady), .outPix(outPix), .outErr(outErr)
  );

  // R3 weight choice
  function automatic int weightOf(input int code, input int otherA);
    case (code)
      0: return 0;
      1: return 255;
      2: return otherA;
      default: return 255 - otherA;
    endcase
  endfunction

  // R4 / R9 per-channel arithmetic with clamp
  function automatic logic [31:0] blendRef(input logic [31:0] s, input logic [31:0] d,
                                           input int c0, input int c1);
    logic [31:0] r;
    int w0, w1, v;
    w0 = weightOf(c0, int'(d[31:24]));
    w1 = weightOf(c1, int'(s[31:24]));
    for (int ch = 0; ch < 4; ch++) begin
      v = (int'(s[ch*8 +: 8]) * w0 + int'(d[ch*8 +: 8]) * w1 + 127) / 255;
      if (v > 255) v = 255;
      r[ch*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  // R5 operator table
  function automatic void opPair(input int m, output int c0, output int c1);
    case (m)
      0:  begin c0 = 0; c1 = 0; end
      1:  begin c0 = 1; c1 = 0; end
      2:  begin c0 = 0; c1 = 1; end
      3:  begin c0 = 1; c1 = 3; end
      4:  begin c0 = 3; c1 = 1; end
      5:  begin c0 = 2; c1 = 0; end
      6:  begin c0 = 0; c1 = 2; end
      7:  begin c0 = 3; c1 = 0; end
      8:  begin c0 = 0; c1 = 3; end
      9:  begin c0 = 2; c1 = 3; end
      10: begin c0 = 3; c1 = 2; end
      default: begin c0 = 3; c1 = 3; end
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expectOf(input logic [31:0] s, input logic [31:0] d,
                                           input int m, input bit dir, input int f0, input int f1,
                                           output bit err);
    int c0, c1;
    err = 1'b0;
    if (dir) return blendRef(s, d, f0, f1);
    if (m >= 12) begin err = 1'b1; return 32'h0; end
    opPair(m, c0, c1);
    return blendRef(s, d, c0, c1);
  endfunction

  task automatic sendOne(input string tag, input logic [31:0] s, input logic [31:0] d,
                         input int m, input bit dir, input int f0, input int f1);
    bit eErr;
    logic [31:0] ePix;
    ePix = expectOf(s, d, m, dir, f0, f1, eErr);
    @(negedge clk);
    srcPix = s; dstPix = d; opMode = 4'(m); useDirect = dir;
    directF0 = 2'(f0); directF1 = 2'(f1); inValid = 1'b1; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " valid"}, {31'd0, outValid}, 32'd1);
    check({tag, " pix"}, outPix, ePix);
    check({tag, " err"}, {31'd0, outErr}, {31'd0, eErr});
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] p1, p2;
    bit e;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 valid in reset", {31'd0, outValid}, 32'd0);
    check("R1 ready in reset", {31'd0, inReady}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {31'd0, outValid}, 32'd0);
    check("R1 ready after reset", {31'd0, inReady}, 32'd1);

    // R6 identities
    sendOne("R6 src", 32'h80402010, 32'hFF0000FF, 1, 0, 0, 0);
    sendOne("R6 dst", 32'h80402010, 32'hFF0000FF, 2, 0, 0, 0);
    sendOne("R6 clear", 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 0, 0);
    // R5 over with half-alpha source, R4 rounding
    sendOne("R5 over", 32'h80800000, 32'hFF0000FF, 3, 0, 0, 0);
    sendOne("R5 xor", 32'h80800000, 32'h40004040, 11, 0, 0, 0);
    // R9 clamp through direct full/full
    sendOne("R9 clamp", 32'hC8C8C8C8, 32'hC8C8C8C8, 0, 1, 1, 1);
    // R7 direct ignores invalid code
    sendOne("R7 direct", 32'h7F102030, 32'h90405060, 15, 1, 2, 3);
    // R8 every invalid code
    for (int m = 12; m < 16; m++) sendOne("R8 invalid", 32'h12345678, 32'h9ABCDEF0, m, 0, 0, 0);
    // R2 backpressure
    p1 = expectOf(32'hFF102030, 32'h00000000, 1, 0, 0, 0, e);
    p2 = expectOf(32'h40404040, 32'h80808080, 3, 0, 0, 0, e);
    @(negedge clk);
    srcPix = 32'hFF102030; dstPix = 32'h0; opMode = 4'd1; useDirect = 1'b0;
    inValid = 1'b1; outReady = 1'b0;
    @(negedge clk);
    check("R2 first out", outPix, p1);
    check("R2 stall ready", {31'd0, inReady}, 32'd0);
    srcPix = 32'h40404040; dstPix = 32'h80808080; opMode = 4'd3;
    @(negedge clk);
    check("R2 held", outPix, p1);
    check("R2 held valid", {31'd0, outValid}, 32'd1);
    check("R2 still blocked", {31'd0, inReady}, 32'd0);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R2 next out", outPix, p2);
    @(negedge clk);
    check("R2 drained", {31'd0, outValid}, 32'd0);

    // random mix: R3 R4 R5 R7 R8
    for (int i = 0; i < 400; i++) begin
      int m;
      bit dir;
      m   = int'($urandom_range(0, 15));
      dir = ($urandom_range(0, 3) == 0);
      sendOne(dir ? "R3 R7 random" : (m >= 12 ? "R8 random" : "R4 R5 random"),
              $urandom, $urandom, m, dir,
              int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
    end
    finishRun();
  end
endmodule